// File: doc/BRIEF.md
# Serial-to-Parallel Word Receiver with Programmable Pixel Clock

This block receives a serial bit stream sampled on its bit-rate clock, finds word boundaries from a fixed two-bit framing marker, and presents each recovered 10-bit word on a parallel bus. A pixel-clock output marks every delivered word with a pulse. The pulse length is a programmable number of bit times, scaled by the link rate multiplier. One encoding of the pulse select turns the pulse polarity around.

A rate-select input of zero places the block in power-down. Power-down resets all internal state and forces the outputs to a parked state. A drive-control input chooses between driving the parked levels and releasing the bus through a separate output-enable. A pass-through control routes an external clock straight to the pixel-clock pin, and in that mode nothing is deserialized onto the clock.

Each frame carries 12 bits on the line: ten data bits with the least significant bit first, then a one, then a zero. A bit counts only in a cycle where the valid input is high. One bit time is one clock cycle, and one reference period is 12 bit times.

Top module: `pxdes_top`

## Requirements
- R1: After reset or loss of lock, the block sets `link_locked` only at the end of the second consecutive frame whose last two bits are 1 then 0, spaced exactly 12 valid bits apart. The first such frame changes neither `link_locked` nor `dout`.
- R2: Serial bit k of a frame (k = 0..9, counted in arrival order) appears on `dout[k]`.
- R3: While locked, one misframed frame (last two bits not 1,0) keeps the lock, and the next good frame is delivered. Two consecutive misframed frames clear `link_locked` at the end of the second one.
- R4: `dout` holds its value while the link is unlocked and across a misframed frame.
- R5: `dout` takes a new word one clock after the frame's final bit is sampled. In that same cycle `pix_clk` enters its active level, which is low, or high when `pw_sel` = 2'b01.
- R6: `pix_clk` stays active for M×W cycles. M is `link_mult` (1, 2 or 3; the value 0 acts as 1). W is 6 for `pw_sel` 2'b00 and 2'b01, 12 for 2'b10 and 16 for 2'b11.
- R7: With `pw_sel` = 2'b01, `pix_clk` idles low and pulses high. With every other code it idles high and pulses low.
- R8: With M = 1, `pw_sel` = 2'b00 and back-to-back frames, `pix_clk` is low for 6 of every 12 cycles.
- R9: With `rate_sel` = 2'b00 and `pd_drive` = 1, the outputs are as follows: `dout` = 0, `pix_clk` = 1, `out_en` = 1 and `link_locked` = 0. This holds regardless of the other inputs.
- R10: With `rate_sel` = 2'b00 and `pd_drive` = 0, `out_en` = 0.
- R11: Power-down clears lock and `dout`. After exit, two aligned frames are again needed to lock.
- R12: With `pass_en` = 1 outside power-down, `pix_clk` follows `pass_clk` with no clock delay.
- R13: Outside power-down, `out_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Rate range; 2'b00 means power-down |
| pd_drive | input | 1 | In power-down: 1 drives parked levels, 0 releases outputs |
| rx_bit | input | 1 | Serial data bit |
| rx_vld | input | 1 | Qualifies `rx_bit` this cycle |
| pw_sel | input | 2 | Pulse width / polarity select |
| link_mult | input | 2 | Link rate multiplier (0 acts as 1) |
| pass_en | input | 1 | Route `pass_clk` to `pix_clk` |
| pass_clk | input | 1 | Clock for pass-through |
| dout | output | 10 | Recovered parallel word |
| pix_clk | output | 1 | Pixel (word) clock |
| out_en | output | 1 | Output-enable; 0 means outputs float |
| link_locked | output | 1 | Frame alignment locked |

## Verification
Words with all ones in the data field let the lock sequence start without stray 1,0 pairs. Asymmetric words such as 0x2C5 and 0x1A3 expose any reversed or shifted bit order. Frames with a broken marker, sent once and then twice, separate tolerance of a single error from loss of lock, and they show that the bus holds during both. Pulse lengths are measured for each width code, for multipliers of 2, 3 and 0, and for the inverted code, and the duty test with streamed frames separates a retriggered pulse from a pulse that overruns.

// File: rtl/pxdes_pkg.sv
// Shared definitions for the pixel deserializer.
package pxdes_pkg;
    // Alignment states of the frame tracker.
    typedef enum logic [1:0] {
        AL_HUNT    = 2'd0,
        AL_CONFIRM = 2'd1,
        AL_LOCK    = 2'd2
    } align_st_e;

    // Pulse width select codes.
    localparam logic [1:0] PW_NARROW     = 2'b00;
    localparam logic [1:0] PW_NARROW_INV = 2'b01;
    localparam logic [1:0] PW_MID        = 2'b10;
    localparam logic [1:0] PW_WIDE       = 2'b11;
endpackage

// File: rtl/pxdes_frame_align.sv
// Frame tracker: shifts in serial bits and hunts for the 1,0 marker that
// closes each FRAME_W-bit frame. It locks after LOCK_HITS aligned frames and
// drops lock after MISS_LIMIT misframed frames in a row.
// Assumes: LOCK_HITS >= 2, MISS_LIMIT >= 1, first bit of a frame is data LSB.
module pxdes_frame_align
    import pxdes_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int LOCK_HITS  = 2,
    parameter int MISS_LIMIT = 2
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              word_stb,
    output logic [DATA_W-1:0] word,
    output logic              locked
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int PH_W    = $clog2(FRAME_W);
    localparam int CT_MAX  = (LOCK_HITS > MISS_LIMIT) ? LOCK_HITS : MISS_LIMIT;
    localparam int CT_W    = $clog2(CT_MAX + 1);

    align_st_e           st;
    logic [FRAME_W-1:0]  sh;
    logic [FRAME_W-1:0]  sh_nxt;
    logic [PH_W-1:0]     phase;
    logic [CT_W-1:0]     hits;
    logic [CT_W-1:0]     misses;
    logic                framed;
    logic                at_edge;
    logic [DATA_W-1:0]   frame_word;

    assign sh_nxt  = {sh[FRAME_W-2:0], bit_in};
    assign framed  = (sh_nxt[1:0] == 2'b10);
    assign at_edge = (phase == PH_W'(FRAME_W - 1));
    assign locked  = (st == AL_LOCK);

    // Purpose: map arrival order onto word bit positions (first bit -> bit 0).
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            frame_word[i] = sh_nxt[FRAME_W-1-i];
        end
    end

    // Purpose: shift, phase counting and hunt/confirm/lock sequencing.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            st       <= AL_HUNT;
            sh       <= '0;
            phase    <= '0;
            hits     <= '0;
            misses   <= '0;
            word_stb <= 1'b0;
            word     <= '0;
        end else begin
            word_stb <= 1'b0;
            if (bit_vld) begin
                sh    <= sh_nxt;
                phase <= at_edge ? '0 : phase + 1'b1;
                unique case (st)
                    AL_HUNT: begin
                        if (framed) begin
                            st    <= AL_CONFIRM;
                            hits  <= CT_W'(1);
                            phase <= '0;
                        end
                    end
                    AL_CONFIRM: begin
                        if (at_edge) begin
                            if (!framed) begin
                                st   <= AL_HUNT;
                                hits <= '0;
                            end else if (hits == CT_W'(LOCK_HITS - 1)) begin
                                st       <= AL_LOCK;
                                misses   <= '0;
                                word_stb <= 1'b1;
                                word     <= frame_word;
                            end else begin
                                hits <= hits + 1'b1;
                            end
                        end
                    end
                    AL_LOCK: begin
                        if (at_edge) begin
                            if (framed) begin
                                misses   <= '0;
                                word_stb <= 1'b1;
                                word     <= frame_word;
                            end else if (misses == CT_W'(MISS_LIMIT - 1)) begin
                                st     <= AL_HUNT;
                                misses <= '0;
                                hits   <= '0;
                            end else begin
                                misses <= misses + 1'b1;
                            end
                        end
                    end
                    default: st <= AL_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/pxdes_width_dec.sv
// Pulse length decoder: turns the width select and link multiplier into a
// pulse length in bit times and a polarity flag.
// Assumes: multiplier code 0 is treated as 1.
module pxdes_width_dec
    import pxdes_pkg::*;
#(
    parameter int W_NARROW = 6,
    parameter int W_MID    = 12,
    parameter int W_WIDE   = 16,
    parameter int CNT_W    = $clog2(3 * W_WIDE + 1)
) (
    input  logic [1:0]       pw_sel,
    input  logic [1:0]       link_mult,
    output logic [CNT_W-1:0] len,
    output logic             invert
);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] mult;

    // Purpose: select base width, polarity and effective multiplier.
    always_comb begin
        unique case (pw_sel)
            PW_NARROW:     base = CNT_W'(W_NARROW);
            PW_NARROW_INV: base = CNT_W'(W_NARROW);
            PW_MID:        base = CNT_W'(W_MID);
            default:       base = CNT_W'(W_WIDE);
        endcase
        invert = (pw_sel == PW_NARROW_INV);
        mult   = (link_mult == 2'd0) ? CNT_W'(1) : CNT_W'(link_mult);
        len    = base * mult;
    end
endmodule

// File: rtl/pxdes_pclk_gen.sv
// Pixel clock pulse generator: a start strobe opens an active phase of
// `len` cycles; a new start during the phase reloads it.
// Assumes: len >= 1.
module pxdes_pclk_gen #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             invert,
    output logic             pclk
);
    logic             active;
    logic [CNT_W-1:0] left;

    // Purpose: count the active phase down and close it.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            active <= 1'b0;
            left   <= '0;
        end else if (start) begin
            active <= 1'b1;
            left   <= len - 1'b1;
        end else if (active) begin
            if (left == '0) begin
                active <= 1'b0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    assign pclk = invert ? active : ~active;
endmodule

// File: rtl/pxdes_top.sv
// Pixel deserializer top: frame tracker, output word register, pulse
// generator, and the power-down / pass-through output selection.
// Assumes: rate_sel 2'b00 means power-down, which also resets the core.
module pxdes_top #(
    parameter int DATA_W     = 10,
    parameter int LOCK_HITS  = 2,
    parameter int MISS_LIMIT = 2,
    parameter int W_NARROW   = 6,
    parameter int W_MID      = 12,
    parameter int W_WIDE     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              pd_drive,
    input  logic              rx_bit,
    input  logic              rx_vld,
    input  logic [1:0]        pw_sel,
    input  logic [1:0]        link_mult,
    input  logic              pass_en,
    input  logic              pass_clk,
    output logic [DATA_W-1:0] dout,
    output logic              pix_clk,
    output logic              out_en,
    output logic              link_locked
);
    localparam int CNT_W = $clog2(3 * W_WIDE + 1);

    logic              pd;
    logic              core_rst_n;
    logic              word_stb;
    logic [DATA_W-1:0] word;
    logic              locked;
    logic [DATA_W-1:0] dout_r;
    logic [CNT_W-1:0]  len;
    logic              invert;
    logic              core_pclk;

    assign pd         = (rate_sel == 2'b00);
    assign core_rst_n = rst_n & ~pd;

    pxdes_frame_align #(
        .DATA_W(DATA_W), .LOCK_HITS(LOCK_HITS), .MISS_LIMIT(MISS_LIMIT)
    ) u_align (
        .clk(clk), .srst_n(core_rst_n), .bit_vld(rx_vld), .bit_in(rx_bit),
        .word_stb(word_stb), .word(word), .locked(locked)
    );

    pxdes_width_dec #(
        .W_NARROW(W_NARROW), .W_MID(W_MID), .W_WIDE(W_WIDE), .CNT_W(CNT_W)
    ) u_wdec (
        .pw_sel(pw_sel), .link_mult(link_mult), .len(len), .invert(invert)
    );

    pxdes_pclk_gen #(.CNT_W(CNT_W)) u_pclk (
        .clk(clk), .srst_n(core_rst_n), .start(word_stb), .len(len),
        .invert(invert), .pclk(core_pclk)
    );

    // Purpose: present a delivered word in step with the pulse start.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            dout_r <= '0;
        end else if (word_stb) begin
            dout_r <= word;
        end
    end

    // Purpose: choose parked, pass-through or live output values.
    always_comb begin
        if (pd) begin
            dout        = '0;
            pix_clk     = 1'b1;
            out_en      = pd_drive;
            link_locked = 1'b0;
        end else begin
            dout        = dout_r;
            pix_clk     = pass_en ? pass_clk : core_pclk;
            out_en      = 1'b1;
            link_locked = locked;
        end
    end
endmodule

// File: rtl/pxdes_top_chk.sv
// Property checker for pxdes_top, attached by bind.
module pxdes_top_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rate_sel,
    input logic              pd_drive,
    input logic [1:0]        pw_sel,
    input logic              pass_en,
    input logic              pass_clk,
    input logic [DATA_W-1:0] dout,
    input logic              pix_clk,
    input logic              out_en,
    input logic              link_locked
);
    // R9
    pd_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b00 && pd_drive) |->
            (dout == '0 && pix_clk && out_en && !link_locked));

    // R10
    pd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b00 && !pd_drive) |-> !out_en);

    // R13
    live_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != 2'b00) |-> out_en);

    // R12
    pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != 2'b00 && pass_en) |-> (pix_clk == pass_clk));

    // R4
    hold_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_locked && rate_sel != 2'b00) |=>
            (rate_sel == 2'b00 || $stable(dout)));

    // R5
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != 2'b00 && $past(rate_sel) != 2'b00 && !pass_en && !$stable(dout))
            |-> (pix_clk == (pw_sel == 2'b01)));
endmodule

bind pxdes_top pxdes_top_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .pd_drive(pd_drive),
    .pw_sel(pw_sel), .pass_en(pass_en), .pass_clk(pass_clk), .dout(dout),
    .pix_clk(pix_clk), .out_en(out_en), .link_locked(link_locked)
);

// File: tb/sim_pxdes_top.sv
// Directed bench for pxdes_top.
module sim_pxdes_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'b01;
    logic       pd_drive = 1'b1;
    logic       rx_bit = 1'b0;
    logic       rx_vld = 1'b0;
    logic [1:0] pw_sel = 2'b00;
    logic [1:0] link_mult = 2'd1;
    logic       pass_en = 1'b0;
    logic       pass_clk = 1'b0;
    logic [9:0] dout;
    logic       pix_clk;
    logic       out_en;
    logic       link_locked;

    int n_chk = 0;
    int n_bad = 0;
    int lows = 0;
    bit count_lows = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pxdes_top u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .pd_drive(pd_drive),
        .rx_bit(rx_bit), .rx_vld(rx_vld), .pw_sel(pw_sel), .link_mult(link_mult),
        .pass_en(pass_en), .pass_clk(pass_clk), .dout(dout), .pix_clk(pix_clk),
        .out_en(out_en), .link_locked(link_locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        rx_vld = 1'b1;
        @(negedge clk);
        if (count_lows && !pix_clk) lows++;
        rx_vld = 1'b0;
    endtask

    // Ten data bits LSB first, then the two marker bits.
    task automatic send_frame(input logic [9:0] d, input logic [1:0] mark);
        for (int i = 0; i < 10; i++) send_bit(d[i]);
        send_bit(mark[1]);
        send_bit(mark[0]);
    endtask

    task automatic idle(input int n);
        rx_vld = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count cycles of active level following a frame end.
    task automatic pulse_len(input logic act_lvl, output int n);
        n = 0;
        @(negedge clk);
        while (pix_clk == act_lvl && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R13 reset oe", out_en, 1);
        chk("R1 reset lock", link_locked, 0);
        chk("R4 reset dout", dout, 0);
        chk("R7 reset idle high", pix_clk, 1);
    endtask

    task automatic t_lock;
        send_frame(10'h3FF, 2'b10);
        chk("R1 one frame no lock", link_locked, 0);
        idle(1);
        chk("R1 one frame no data", dout, 0);
        send_frame(10'h2C5, 2'b10);
        chk("R1 second frame lock", link_locked, 1);
        chk("R5 data not before edge", dout, 0);
        idle(1);
        chk("R2 bit order", dout, 10'h2C5);
        chk("R5 pulse starts with data", pix_clk, 0);
        idle(10);
    endtask

    task automatic t_width(input logic [1:0] sel, input logic [1:0] m,
                           input logic [9:0] d, input int exp);
        int n;
        pw_sel = sel;
        link_mult = m;
        send_frame(d, 2'b10);
        pulse_len(1'b0, n);
        chk("R6 pulse length", n, exp);
        chk("R6 word", dout, d);
    endtask

    task automatic t_invert;
        int n;
        pw_sel = 2'b01;
        link_mult = 2'd1;
        idle(2);
        chk("R7 inverted idle low", pix_clk, 0);
        send_frame(10'h0A5, 2'b10);
        pulse_len(1'b1, n);
        chk("R7 inverted high length", n, 6);
        pw_sel = 2'b00;
        idle(1);
    endtask

    task automatic t_duty;
        pw_sel = 2'b00;
        link_mult = 2'd1;
        send_frame(10'h155, 2'b10);
        send_frame(10'h2AA, 2'b10);
        lows = 0;
        count_lows = 1'b1;
        send_frame(10'h0F0, 2'b10);
        count_lows = 1'b0;
        chk("R8 low cycles per frame", lows, 6);
        idle(12);
    endtask

    task automatic t_miss;
        send_frame(10'h3FF, 2'b11);
        chk("R3 single miss keeps lock", link_locked, 1);
        idle(2);
        chk("R4 misframe holds", dout, 10'h0F0);
        send_frame(10'h1A3, 2'b10);
        idle(1);
        chk("R3 next good delivered", dout, 10'h1A3);
        send_frame(10'h3FF, 2'b11);
        send_frame(10'h3FF, 2'b11);
        chk("R3 two misses unlock", link_locked, 0);
        send_frame(10'h3FF, 2'b10);
        idle(1);
        chk("R4 unlocked holds", dout, 10'h1A3);
        chk("R1 relock needs two", link_locked, 0);
        send_frame(10'h155, 2'b10);
        idle(1);
        chk("R1 relock", link_locked, 1);
        chk("R1 relock data", dout, 10'h155);
        idle(12);
    endtask

    task automatic t_pd;
        rate_sel = 2'b00;
        pd_drive = 1'b1;
        pass_en = 1'b1;
        pass_clk = 1'b0;
        #1;
        chk("R9 pd dout", dout, 0);
        chk("R9 pd pclk", pix_clk, 1);
        chk("R9 pd oe", out_en, 1);
        chk("R9 pd lock", link_locked, 0);
        pass_en = 1'b0;
        pd_drive = 1'b0;
        #1;
        chk("R10 float oe", out_en, 0);
        idle(2);
        rate_sel = 2'b11;
        pd_drive = 1'b1;
        idle(1);
        chk("R11 lock cleared", link_locked, 0);
        chk("R11 dout cleared", dout, 0);
        send_frame(10'h3FF, 2'b10);
        chk("R11 one frame no lock", link_locked, 0);
        send_frame(10'h311, 2'b10);
        idle(1);
        chk("R11 relocked", link_locked, 1);
        chk("R11 data", dout, 10'h311);
        idle(12);
    endtask

    task automatic t_pass;
        pass_en = 1'b1;
        pass_clk = 1'b1;
        #1;
        chk("R12 pass high", pix_clk, 1);
        pass_clk = 1'b0;
        #1;
        chk("R12 pass low", pix_clk, 0);
        pass_clk = 1'b1;
        #1;
        chk("R12 pass high again", pix_clk, 1);
        pass_en = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_width(2'b00, 2'd1, 10'h001, 6);
        t_width(2'b10, 2'd1, 10'h200, 12);
        t_width(2'b11, 2'd1, 10'h123, 16);
        t_width(2'b00, 2'd2, 10'h0F0, 12);
        t_width(2'b11, 2'd3, 10'h3C3, 48);
        t_width(2'b00, 2'd0, 10'h0F0, 6);
        t_invert();
        t_duty();
        t_miss();
        t_pd();
        t_pass();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule